// File: doc/BRIEF.md
# Multi-Port Bus Crossbar with Per-Target Arbitration

This block joins `N_UP` bus initiators to `N_DN` bus targets over a classic single-clock bus with cycle, strobe, write-enable, byte-select, address and data signals, and acknowledge and error responses. Each initiator port has its own address decoder. The decoder compares the request address against a base/mask pair for every target port. The first pair that matches picks the target. An address that matches no pair is answered locally with a one-clock error, and no target sees it.

Each target port owns an arbiter. A parameter selects the policy for all target ports: fixed (the lowest initiator index wins) or rotating. In rotating mode a pointer advances by one place each time that target port grants. The winner keeps the target port for as long as it holds its cycle signal, so block transfers stay whole. While it owns the port, its request fields are steered to the target and the target's responses are steered back to it. Initiators that go to different target ports are served at the same time. An initiator that is waiting sees acknowledge and error held low.

Top module: `wbx_crossbar`

## Requirements
- R1: Target port j is selected when `(adr & MASK_j) == BASE_j`, and the lowest matching j wins. With the defaults, target 0 covers 0x0000–0x0FFF and target 1 covers 0x0000–0x3FFF, so 0x0800 goes to target 0 and 0x2000 goes to target 1.
- R2: An active strobe whose address matches no range raises that initiator's error in the next cycle for exactly one clock, even if the strobe stays high. No target cycle or strobe is raised for it.
- R3: A request to an idle target port is granted at the next clock edge. From then on, that target's cycle, strobe, write-enable, byte-select, address and write data equal the owner's values.
- R4: While granted, the owner's acknowledge, error and read data equal the target's acknowledge, error and read data in the same cycle.
- R5: An initiator that does not own the target port it addresses sees acknowledge and error low, so its cycle stalls.
- R6: Initiators that address different target ports are granted in the same cycle and are served at the same time.
- R7: Ownership lasts while the owner's cycle signal is high, including cycles with the strobe low. Ownership ends at the first clock edge that sees the cycle signal low. A waiting initiator is granted at the following edge.
- R8: In fixed mode (`ARB = ARB_FIXED`), the lowest-indexed requesting initiator wins.
- R9: In rotating mode (`ARB = ARB_ROUND`), each target port's pointer is 0 after reset and advances by one (mod `N_UP`) at each grant. The search starts at the pointer and moves upward with wrap-around. The first requester found wins.
- R10: The byte-select lanes of the owner reach the target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_cyc_i | input | N_UP | Initiator cycle signals |
| up_stb_i | input | N_UP | Initiator strobes |
| up_we_i | input | N_UP | Initiator write enables |
| up_sel_i | input | N_UP*SW | Initiator byte selects |
| up_adr_i | input | N_UP*AW | Initiator addresses |
| up_dat_i | input | N_UP*DW | Initiator write data |
| up_dat_o | output | N_UP*DW | Read data to initiators |
| up_ack_o | output | N_UP | Acknowledge to initiators |
| up_err_o | output | N_UP | Error to initiators |
| dn_cyc_o | output | N_DN | Target cycle signals |
| dn_stb_o | output | N_DN | Target strobes |
| dn_we_o | output | N_DN | Target write enables |
| dn_sel_o | output | N_DN*SW | Target byte selects |
| dn_adr_o | output | N_DN*AW | Target addresses |
| dn_dat_o | output | N_DN*DW | Target write data |
| dn_dat_i | input | N_DN*DW | Target read data |
| dn_ack_i | input | N_DN | Target acknowledges |
| dn_err_i | input | N_DN | Target errors |

## Verification
A wrong owner register shows up one edge after the grant. The target address then carries another initiator's value, or an acknowledge reaches an initiator that is still waiting. A stuck busy flag shows up as a target cycle signal that stays high after the owner has released it, or as a waiting initiator that is never granted two edges after the release. A rotating pointer that fails to advance shows up at the next contended grant: a different initiator wins from the one the rotation predicts. A decoder fault shows up at the first edge after the strobe, as the wrong target strobe or as a missing or stray error pulse.

// File: rtl/wbx_pkg.sv
// Shared types for the crossbar.
// Assumes: nothing beyond IEEE 1800-2017.
package wbx_pkg;
    typedef enum logic {ARB_FIXED = 1'b0, ARB_ROUND = 1'b1} arb_mode_e;
endpackage

// File: rtl/wbx_decode.sv
// Address decoder for one initiator port. It checks every base/mask pair
// and returns a one-hot target select, lowest index first.
// Assumes: the ranges come from parameters; miss is qualified by cyc & stb.
module wbx_decode #(
    parameter int AW   = 16,
    parameter int N_DN = 2,
    parameter logic [N_DN*AW-1:0] BASE = '0,
    parameter logic [N_DN*AW-1:0] MASK = '0
) (
    input  logic            cyc,
    input  logic            stb,
    input  logic [AW-1:0]   adr,
    output logic [N_DN-1:0] hit,
    output logic            miss
);
    logic taken;

    // First matching range claims the address.
    always_comb begin
        hit   = '0;
        taken = 1'b0;
        for (int j = 0; j < N_DN; j++) begin
            if (!taken && ((adr & MASK[j*AW +: AW]) == BASE[j*AW +: AW])) begin
                hit[j] = 1'b1;
                taken  = 1'b1;
            end
        end
        miss = cyc && stb && !taken;
    end
endmodule

// File: rtl/wbx_arb.sv
// Arbiter for one target port. It holds the owner while the owner keeps its
// cycle signal high. The policy is fixed (low index first) or rotating
// (pointer steps by one at each grant).
// Assumes: req already includes cyc, stb and the address decode.
module wbx_arb import wbx_pkg::*; #(
    parameter int        N_UP = 3,
    parameter arb_mode_e ARB  = ARB_FIXED,
    localparam int       IW   = (N_UP > 1) ? $clog2(N_UP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_UP-1:0] req,
    input  logic [N_UP-1:0] cyc,
    output logic            busy,
    output logic [IW-1:0]   owner
);
    logic [IW-1:0]   ptr;
    logic [IW-1:0]   win;
    logic            found;
    logic [N_UP-1:0] req_q;
    logic [N_UP-1:0] low_mask;

    // Search for a requester, starting at the pointer and wrapping around.
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < N_UP; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N_UP) idx = idx - N_UP;
            if (!found && req[idx]) begin
                found = 1'b1;
                win   = IW'(idx);
            end
        end
    end

    // Ownership: grant when idle, release when the owner's cycle drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            owner <= '0;
            ptr   <= '0;
        end else if (busy) begin
            if (!cyc[owner]) busy <= 1'b0;
        end else if (found) begin
            busy  <= 1'b1;
            owner <= win;
            if (ARB == ARB_ROUND)
                ptr <= (ptr == IW'(N_UP - 1)) ? '0 : ptr + 1'b1;
        end
    end

    // Copy of the last cycle's requests, used only by the assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req;
    end

    // Initiators with a lower index than the current owner.
    always_comb begin
        for (int i = 0; i < N_UP; i++) low_mask[i] = (i < int'(owner));
    end

    AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n) (busy && cyc[owner]) |=> (busy && $stable(owner))); // R7
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (busy && !cyc[owner]) |=> !busy); // R7
    AST_GRANT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> req_q[owner]); // R3

    generate
        if (ARB == ARB_FIXED) begin : g_fixed_chk
            AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> ((req_q & low_mask) == '0)); // R8
        end else begin : g_round_chk
            AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (ptr == IW'((int'($past(ptr)) + 1) % N_UP))); // R9
            AST_RR_STILL: assert property (@(posedge clk) disable iff (!rst_n) !$rose(busy) |-> $stable(ptr)); // R9
        end
    endgenerate
endmodule

// File: rtl/wbx_crossbar.sv
// Crossbar between N_UP initiators and N_DN targets. Each initiator has a
// decoder. Each target has an arbiter. Request and response multiplexers
// follow the arbiter owners. Unmatched addresses get a one-clock local error.
// Assumes: a single clock; initiators hold cyc for the whole block transfer.
module wbx_crossbar import wbx_pkg::*; #(
    parameter int        N_UP = 3,
    parameter int        N_DN = 2,
    parameter int        AW   = 16,
    parameter int        DW   = 32,
    parameter arb_mode_e ARB  = ARB_FIXED,
    parameter logic [N_DN*AW-1:0] DN_BASE = {16'h0000, 16'h0000},
    parameter logic [N_DN*AW-1:0] DN_MASK = {16'hC000, 16'hF000},
    localparam int       SW   = DW / 8,
    localparam int       IW   = (N_UP > 1) ? $clog2(N_UP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_UP-1:0]    up_cyc_i,
    input  logic [N_UP-1:0]    up_stb_i,
    input  logic [N_UP-1:0]    up_we_i,
    input  logic [N_UP*SW-1:0] up_sel_i,
    input  logic [N_UP*AW-1:0] up_adr_i,
    input  logic [N_UP*DW-1:0] up_dat_i,
    output logic [N_UP*DW-1:0] up_dat_o,
    output logic [N_UP-1:0]    up_ack_o,
    output logic [N_UP-1:0]    up_err_o,
    output logic [N_DN-1:0]    dn_cyc_o,
    output logic [N_DN-1:0]    dn_stb_o,
    output logic [N_DN-1:0]    dn_we_o,
    output logic [N_DN*SW-1:0] dn_sel_o,
    output logic [N_DN*AW-1:0] dn_adr_o,
    output logic [N_DN*DW-1:0] dn_dat_o,
    input  logic [N_DN*DW-1:0] dn_dat_i,
    input  logic [N_DN-1:0]    dn_ack_i,
    input  logic [N_DN-1:0]    dn_err_i
);
    logic [N_DN-1:0] hit   [N_UP];
    logic [N_UP-1:0] miss;
    logic [N_UP-1:0] err_q;
    logic [N_UP-1:0] req   [N_DN];
    logic            busy  [N_DN];
    logic [IW-1:0]   owner [N_DN];

    genvar gi, gj;
    generate
        for (gi = 0; gi < N_UP; gi++) begin : g_dec
            wbx_decode #(.AW(AW), .N_DN(N_DN), .BASE(DN_BASE), .MASK(DN_MASK)) u_dec (
                .cyc (up_cyc_i[gi]),
                .stb (up_stb_i[gi]),
                .adr (up_adr_i[gi*AW +: AW]),
                .hit (hit[gi]),
                .miss(miss[gi])
            );
            AST_ACK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) up_ack_o[gi] |-> (up_cyc_i[gi] && up_stb_i[gi])); // R5
        end
        for (gj = 0; gj < N_DN; gj++) begin : g_arb
            wbx_arb #(.N_UP(N_UP), .ARB(ARB)) u_arb (
                .clk  (clk),
                .rst_n(rst_n),
                .req  (req[gj]),
                .cyc  (up_cyc_i),
                .busy (busy[gj]),
                .owner(owner[gj])
            );
            AST_STB_IN_CYC: assert property (@(posedge clk) disable iff (!rst_n) dn_stb_o[gj] |-> dn_cyc_o[gj]); // R3
        end
    endgenerate

    // Build each target's request vector from the decoded strobes.
    always_comb begin
        for (int j = 0; j < N_DN; j++)
            for (int i = 0; i < N_UP; i++)
                req[j][i] = up_cyc_i[i] && up_stb_i[i] && hit[i][j];
    end

    // Local error: one clock per unmatched strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= miss & ~err_q;
    end

    // Request direction: each target follows its owner's signals.
    always_comb begin
        dn_cyc_o = '0;
        dn_stb_o = '0;
        dn_we_o  = '0;
        dn_sel_o = '0;
        dn_adr_o = '0;
        dn_dat_o = '0;
        for (int j = 0; j < N_DN; j++) begin
            int o;
            o = int'(owner[j]);
            if (busy[j]) begin
                dn_cyc_o[j]           = up_cyc_i[o];
                dn_stb_o[j]           = up_stb_i[o] && hit[o][j];
                dn_we_o[j]            = up_we_i[o];
                dn_sel_o[j*SW +: SW]  = up_sel_i[o*SW +: SW];
                dn_adr_o[j*AW +: AW]  = up_adr_i[o*AW +: AW];
                dn_dat_o[j*DW +: DW]  = up_dat_i[o*DW +: DW];
            end
        end
    end

    // Response direction: each initiator hears only the target it owns.
    always_comb begin
        up_ack_o = '0;
        up_err_o = err_q;
        up_dat_o = '0;
        for (int i = 0; i < N_UP; i++) begin
            for (int j = 0; j < N_DN; j++) begin
                if (busy[j] && (int'(owner[j]) == i) && hit[i][j]) begin
                    up_ack_o[i]          = up_ack_o[i] | dn_ack_i[j];
                    up_err_o[i]          = up_err_o[i] | dn_err_i[j];
                    up_dat_o[i*DW +: DW] = dn_dat_i[j*DW +: DW];
                end
            end
        end
    end
endmodule

// File: tb/wbx_crossbar_test.sv
module wbx_crossbar_test;
    import wbx_pkg::*;
    localparam int N_UP = 3, N_DN = 2, AW = 16, DW = 32, SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N_UP-1:0]    up_cyc = '0, up_stb = '0, up_we = '0;
    logic [N_UP*SW-1:0] up_sel = '0;
    logic [N_UP*AW-1:0] up_adr = '0;
    logic [N_UP*DW-1:0] up_dat = '0;
    logic               s_err = 1'b0;

    logic [N_UP*DW-1:0] up_dat_f, up_dat_r;
    logic [N_UP-1:0]    up_ack_f, up_err_f, up_ack_r, up_err_r;
    logic [N_DN-1:0]    dn_cyc_f, dn_stb_f, dn_we_f, dn_ack_f, dn_err_f;
    logic [N_DN-1:0]    dn_cyc_r, dn_stb_r, dn_we_r, dn_ack_r, dn_err_r;
    logic [N_DN*SW-1:0] dn_sel_f, dn_sel_r;
    logic [N_DN*AW-1:0] dn_adr_f, dn_adr_r;
    logic [N_DN*DW-1:0] dn_wd_f, dn_wd_r, dn_rd_f, dn_rd_r;

    int checks = 0;
    int fails  = 0;

    function automatic logic [31:0] slave_data(int j, logic [15:0] a);
        return {8'hD0 + 8'(j), 8'h00, a};
    endfunction

    function automatic int exp_port(logic [15:0] a);
        if (a[15:12] == 4'h0) return 0;
        if (a[15:14] == 2'b00) return 1;
        return -1;
    endfunction

    // Target models: zero-wait response, error when s_err is set.
    assign dn_ack_f = dn_stb_f & {N_DN{~s_err}};
    assign dn_err_f = dn_stb_f & {N_DN{s_err}};
    assign dn_ack_r = dn_stb_r & {N_DN{~s_err}};
    assign dn_err_r = dn_stb_r & {N_DN{s_err}};
    genvar g;
    generate
        for (g = 0; g < N_DN; g++) begin : g_slv
            assign dn_rd_f[g*DW +: DW] = slave_data(g, dn_adr_f[g*AW +: AW]);
            assign dn_rd_r[g*DW +: DW] = slave_data(g, dn_adr_r[g*AW +: AW]);
        end
    endgenerate

    wbx_crossbar #(.ARB(ARB_FIXED)) uut (
        .clk(clk), .rst_n(rst_n), .up_cyc_i(up_cyc), .up_stb_i(up_stb), .up_we_i(up_we),
        .up_sel_i(up_sel), .up_adr_i(up_adr), .up_dat_i(up_dat), .up_dat_o(up_dat_f),
        .up_ack_o(up_ack_f), .up_err_o(up_err_f), .dn_cyc_o(dn_cyc_f), .dn_stb_o(dn_stb_f),
        .dn_we_o(dn_we_f), .dn_sel_o(dn_sel_f), .dn_adr_o(dn_adr_f), .dn_dat_o(dn_wd_f),
        .dn_dat_i(dn_rd_f), .dn_ack_i(dn_ack_f), .dn_err_i(dn_err_f));

    wbx_crossbar #(.ARB(ARB_ROUND)) uut_rr (
        .clk(clk), .rst_n(rst_n), .up_cyc_i(up_cyc), .up_stb_i(up_stb), .up_we_i(up_we),
        .up_sel_i(up_sel), .up_adr_i(up_adr), .up_dat_i(up_dat), .up_dat_o(up_dat_r),
        .up_ack_o(up_ack_r), .up_err_o(up_err_r), .dn_cyc_o(dn_cyc_r), .dn_stb_o(dn_stb_r),
        .dn_we_o(dn_we_r), .dn_sel_o(dn_sel_r), .dn_adr_o(dn_adr_r), .dn_dat_o(dn_wd_r),
        .dn_dat_i(dn_rd_r), .dn_ack_i(dn_ack_r), .dn_err_i(dn_err_r));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input int i, input logic c, input logic s, input logic w,
                         input logic [3:0] sl, input logic [15:0] a, input logic [31:0] d);
        up_cyc[i] = c;
        up_stb[i] = s;
        up_we[i]  = w;
        up_sel[i*SW +: SW] = sl;
        up_adr[i*AW +: AW] = a;
        up_dat[i*DW +: DW] = d;
    endtask

    task automatic idle_all();
        up_cyc = '0;
        up_stb = '0;
    endtask

    task automatic do_reset();
        idle_all();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int sets [3][2];
        int exp_f [3];
        int exp_r [3];
        void'($urandom(32'd4242));
        do_reset();
        @(negedge clk);
        // Reset state
        chk("R5 reset ack", 64'(up_ack_f), 64'h0);
        chk("R2 reset err", 64'(up_err_f), 64'h0);
        chk("R3 reset dn_cyc", 64'(dn_cyc_f), 64'h0);

        // R3/R10: single write, first-match goes to target 0 (R1)
        drive(0, 1, 1, 1, 4'b0101, 16'h0800, 32'hCAFE0001);
        #1 chk("R3 no grant before edge", 64'(up_ack_f[0]), 64'h0);
        @(negedge clk);
        chk("R1 first match target", 64'(dn_cyc_f), 64'h1);
        chk("R3 address", 64'(dn_adr_f[15:0]), 64'h0800);
        chk("R3 write data", 64'(dn_wd_f[31:0]), 64'hCAFE0001);
        chk("R3 we", 64'(dn_we_f[0]), 64'h1);
        chk("R10 sel", 64'(dn_sel_f[3:0]), 64'h5);
        chk("R4 ack", 64'(up_ack_f[0]), 64'h1);
        chk("R4 read data", 64'(up_dat_f[31:0]), 64'(slave_data(0, 16'h0800)));
        idle_all();
        @(negedge clk);
        @(negedge clk);

        // R1: range of target 1 only
        drive(1, 1, 1, 0, 4'hF, 16'h2000, 32'h0);
        @(negedge clk);
        chk("R1 second range", 64'(dn_cyc_f), 64'h2);
        chk("R4 read data t1", 64'(up_dat_f[63:32]), 64'(slave_data(1, 16'h2000)));
        idle_all();
        repeat (2) @(negedge clk);

        // R2: miss gives a one-clock error and no target activity
        drive(2, 1, 1, 0, 4'hF, 16'h5000, 32'h0);
        @(negedge clk);
        chk("R2 err raised", 64'(up_err_f[2]), 64'h1);
        chk("R2 no target", 64'(dn_cyc_f | dn_stb_f), 64'h0);
        @(negedge clk);
        chk("R2 err one clock", 64'(up_err_f[2]), 64'h0);
        idle_all();
        repeat (2) @(negedge clk);

        // R6: concurrent transfers to different targets
        drive(0, 1, 1, 0, 4'hF, 16'h0100, 32'h0);
        drive(2, 1, 1, 0, 4'hF, 16'h2000, 32'h0);
        @(negedge clk);
        chk("R6 both acked", 64'({up_ack_f[2], up_ack_f[0]}), 64'h3);
        chk("R6 data up0", 64'(up_dat_f[31:0]), 64'(slave_data(0, 16'h0100)));
        chk("R6 data up2", 64'(up_dat_f[95:64]), 64'(slave_data(1, 16'h2000)));
        idle_all();
        repeat (2) @(negedge clk);

        // R8/R5: contention on target 1 under fixed priority
        drive(0, 1, 1, 0, 4'hF, 16'h3000, 32'h0);
        drive(2, 1, 1, 0, 4'hF, 16'h2004, 32'h0);
        @(negedge clk);
        chk("R8 low index wins", 64'(dn_adr_f[31:16]), 64'h3000);
        chk("R5 loser no ack", 64'(up_ack_f[2]), 64'h0);
        chk("R5 loser no err", 64'(up_err_f[2]), 64'h0);
        idle_all();
        repeat (2) @(negedge clk);

        // R4: target error passes to owner
        s_err = 1'b1;
        drive(1, 1, 1, 0, 4'hF, 16'h0200, 32'h0);
        @(negedge clk);
        chk("R4 target err", 64'({up_err_f[1], up_ack_f[1]}), 64'h2);
        s_err = 1'b0;
        idle_all();
        repeat (2) @(negedge clk);

        // R7: hold through idle strobe, release, then waiting initiator
        drive(1, 1, 1, 0, 4'hF, 16'h0040, 32'h0);
        @(negedge clk);
        drive(1, 1, 0, 0, 4'hF, 16'h0040, 32'h0);
        drive(0, 1, 1, 0, 4'hF, 16'h0050, 32'h0);
        repeat (2) @(negedge clk);
        chk("R7 held cyc", 64'(dn_cyc_f[0]), 64'h1);
        chk("R7 held owner", 64'(dn_adr_f[15:0]), 64'h0040);
        chk("R5 waiter stalls", 64'(up_ack_f[0]), 64'h0);
        up_cyc[1] = 1'b0;
        @(negedge clk);
        chk("R7 released", 64'(dn_cyc_f[0]), 64'h0);
        @(negedge clk);
        chk("R7 waiter granted", 64'(dn_adr_f[15:0]), 64'h0050);
        chk("R7 waiter ack", 64'(up_ack_f[0]), 64'h1);
        idle_all();
        repeat (2) @(negedge clk);

        // R8/R9: three contended rounds on target 0 from a fresh reset
        do_reset();
        @(negedge clk);
        sets[0] = '{1, 2}; exp_f[0] = 1; exp_r[0] = 1;
        sets[1] = '{0, 2}; exp_f[1] = 0; exp_r[1] = 2;
        sets[2] = '{0, 1}; exp_f[2] = 0; exp_r[2] = 0;
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 2; k++)
                drive(sets[r][k], 1, 1, 0, 4'hF, 16'(16 * (sets[r][k] + 1)), 32'h0);
            @(negedge clk);
            chk("R8 fixed winner", 64'(dn_adr_f[15:0]), 64'(16 * (exp_f[r] + 1)));
            chk("R9 rotating winner", 64'(dn_adr_r[15:0]), 64'(16 * (exp_r[r] + 1)));
            idle_all();
            repeat (2) @(negedge clk);
        end

        // Random single transfers, one initiator at a time
        for (int n = 0; n < 200; n++) begin
            int i, p;
            logic [15:0] a;
            logic [3:0]  sl;
            logic [31:0] d;
            logic        w;
            i  = int'($urandom % 3);
            a  = 16'($urandom) & 16'h7FFF;
            sl = 4'($urandom);
            d  = $urandom;
            w  = 1'($urandom);
            p  = exp_port(a);
            drive(i, 1, 1, w, sl, a, d);
            @(negedge clk);
            if (p < 0) begin
                chk("R2 random miss err", 64'(up_err_f[i]), 64'h1);
                chk("R2 random miss quiet", 64'(dn_cyc_r | dn_cyc_f), 64'h0);
            end else begin
                chk("R1 random route", 64'(dn_cyc_f), 64'(1 << p));
                chk("R3 random adr", 64'(dn_adr_f[p*AW +: AW]), 64'(a));
                chk("R3 random wdata", 64'(dn_wd_f[p*DW +: DW]), 64'(d));
                chk("R3 random we", 64'(dn_we_f[p]), 64'(w));
                chk("R10 random sel", 64'(dn_sel_f[p*SW +: SW]), 64'(sl));
                chk("R4 random ack", 64'(up_ack_f[i]), 64'h1);
                chk("R4 random rdata", 64'(up_dat_f[i*DW +: DW]), 64'(slave_data(p, a)));
                chk("R9 rotating single route", 64'(dn_adr_r[p*AW +: AW]), 64'(a));
            end
            idle_all();
            repeat (2) @(negedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule